// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block holds the event flags of a full-speed USB device controller and turns them into one level interrupt request. Single-cycle event pulses from the serial engine set sticky flags. The flags cover packet-memory overrun, bus error, wakeup, suspend, bus reset, start of frame and missed (expected) start of frame. Software reads the register through a simple read/write port. It clears the flags it has serviced by writing 0 to those bits and 1 to every bit it wants to keep. Because of this, a flag that hardware sets between a software read and the following write is never lost.

The top bit is a read-only transaction-complete summary. It is built from the per-endpoint pending bits, which the endpoint registers hold. Next to it the register reports the direction and number of the endpoint being reported. A small two-state machine follows the force-reset control input. In state `ST_LIVE` the peripheral runs normally. The transition `LIVE_TO_FORCED` is taken on the first cycle `force_rst` is seen high. That transition raises the bus-reset flag. In state `ST_FORCED` the peripheral reset output is held. The transition `FORCED_TO_LIVE` is taken once `force_rst` is low again.

Top module: `usb_istr`

## Requirements
- R1: After reset every bit of the register reads 0. The register answers at address 0x44. A read at any other address returns 0x0000.
- R2: The event flags sit at these register bits, driven by `hw_evt` bits 6..0 in order: packet-memory overrun at bit 14, error at 13, wakeup at 12, suspend at 11, bus reset at 10, start of frame at 9 and expected start of frame at 8. Bits 7:5 always read 0.
- R3: A 1 on a `hw_evt` bit at a clock edge sets the matching flag. The flag stays set until software clears it.
- R4: A write to 0x44 clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. A write can never set a flag.
- R5: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when some register bit n in 15..8 is 1 and `irq_mask[n-8]` is 1. Several pending bits give one level request. The request stays high while any enabled bit remains set.
- R7: Bit 15 (transaction complete) is 1 whenever any bit of `ep_ctr_in` or `ep_ctr_out` is 1, and 0 otherwise. Bit 15 cannot be written.
- R8: Bits 3:0 give the lowest-numbered endpoint with a pending bit. Bit 4 is 1 if that endpoint's OUT bit is pending and 0 otherwise. With nothing pending, bits 4:0 read 0.
- R9: `periph_rst` goes high one cycle after `force_rst` is sampled high and stays high while `force_rst` stays high. It falls one cycle after `force_rst` is sampled low. The edge that first samples `force_rst` high also sets the bus-reset flag (bit 10).
- R10: Data written to bits 15 and 7:0 has no effect. Writes to any address other than 0x44 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_rst | input | 1 | Software force-reset control |
| hw_evt | input | 7 | Event pulses, bit 6 overrun down to bit 0 expected SOF |
| ep_ctr_in | input | NUM_EP | Per-endpoint IN transaction-complete pending |
| ep_ctr_out | input | NUM_EP | Per-endpoint OUT transaction-complete pending |
| irq_mask | input | 8 | Enable for register bits 15..8 |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Level interrupt request |
| periph_rst | output | 1 | Peripheral held in reset |

## Verification
The bench targets the write that clears one flag while a new event for that same flag arrives. A design that lets the clear win drops the event without a trace. Writes of all ones are mixed with writes that hit the read-only and reserved bits, which would expose a design that sets flags or corrupts the endpoint fields from the bus. Several endpoints are made pending at once, some with both directions, which shows an encoder that picks the wrong endpoint or the wrong direction. The force-reset input is toggled and held so that a design that sets the reset flag every held cycle, or releases the reset early, gives a wrong readback.

// File: rtl/usb_istr_pkg.sv
package usb_istr_pkg;
    localparam int NUM_FLAGS = 7;
    localparam int FLAG_LSB  = 8;
    localparam int BIT_CTR   = 15;
    localparam int BIT_DIR   = 4;
    localparam int IDX_BUSRST = 2;

    typedef enum logic [0:0] {
        ST_LIVE   = 1'b0,
        ST_FORCED = 1'b1
    } rst_state_e;
endpackage

// File: rtl/usb_istr_rst_fsm.sv
module usb_istr_rst_fsm
    import usb_istr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_rst,
    output logic held,
    output logic enter_pulse
);
    rst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIVE:   if (force_rst)  state_d = ST_FORCED;
            ST_FORCED: if (!force_rst) state_d = ST_LIVE;
            default:   state_d = ST_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        held        = 1'b0;
        enter_pulse = 1'b0;
        unique case (state_q)
            ST_LIVE:   enter_pulse = force_rst;
            ST_FORCED: held = 1'b1;
            default:   held = 1'b0;
        endcase
    end
endmodule

// File: rtl/usb_istr_flags.sv
module usb_istr_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_en,
    input  logic [N-1:0] keep_vec,
    output logic [N-1:0] flags
);
    for (genvar b = 0; b < N; b++) begin : g_flag
        logic kept;
        assign kept = clr_en ? (flags[b] & keep_vec[b]) : flags[b];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[b] <= 1'b0;
            else        flags[b] <= kept | set_vec[b];
        end
    end
endmodule

// File: rtl/usb_istr_ep_enc.sv
module usb_istr_ep_enc #(
    parameter int NUM_EP = 8,
    localparam int ID_W  = 4
) (
    input  logic [NUM_EP-1:0] pend_in,
    input  logic [NUM_EP-1:0] pend_out,
    output logic              any_pend,
    output logic              dir,
    output logic [ID_W-1:0]   ep_id
);
    always_comb begin
        any_pend = |(pend_in | pend_out);
        dir      = 1'b0;
        ep_id    = '0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if (pend_in[i] || pend_out[i]) begin
                ep_id = ID_W'(i);
                dir   = pend_out[i];
            end
        end
    end
endmodule

// File: rtl/usb_istr.sv
module usb_istr
    import usb_istr_pkg::*;
#(
    parameter int          NUM_EP     = 8,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  REG_OFFSET = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_rst,
    input  logic [6:0]        hw_evt,
    input  logic [NUM_EP-1:0] ep_ctr_in,
    input  logic [NUM_EP-1:0] ep_ctr_out,
    input  logic [7:0]        irq_mask,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq,
    output logic              periph_rst
);
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    logic                 wr_hit;
    logic                 enter_pulse;
    logic [NUM_FLAGS-1:0] set_any;
    logic [NUM_FLAGS-1:0] flags_q;
    logic                 ctr_any;
    logic                 ep_dir;
    logic [3:0]           ep_num;
    logic [15:0]          istr_val;

    assign wr_hit = bus_wr && (bus_addr == OFFS);

    usb_istr_rst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_rst   (force_rst),
        .held        (periph_rst),
        .enter_pulse (enter_pulse)
    );

    always_comb begin
        set_any             = hw_evt;
        set_any[IDX_BUSRST] = hw_evt[IDX_BUSRST] | enter_pulse;
    end

    usb_istr_flags #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_any),
        .clr_en   (wr_hit),
        .keep_vec (bus_wdata[FLAG_LSB +: NUM_FLAGS]),
        .flags    (flags_q)
    );

    usb_istr_ep_enc #(.NUM_EP(NUM_EP)) u_enc (
        .pend_in  (ep_ctr_in),
        .pend_out (ep_ctr_out),
        .any_pend (ctr_any),
        .dir      (ep_dir),
        .ep_id    (ep_num)
    );

    always_comb begin
        istr_val                         = '0;
        istr_val[BIT_CTR]                = ctr_any;
        istr_val[FLAG_LSB +: NUM_FLAGS]  = flags_q;
        istr_val[BIT_DIR]                = ep_dir;
        istr_val[3:0]                    = ep_num;
    end

    assign bus_rdata = (bus_addr == OFFS) ? istr_val : 16'h0000;
    assign irq       = |(istr_val[15:8] & irq_mask);
endmodule

// File: rtl/usb_istr_chk.sv
module usb_istr_chk #(
    parameter int NUM_EP = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              force_rst,
    input logic [6:0]        hw_evt,
    input logic [NUM_EP-1:0] ep_ctr_in,
    input logic [NUM_EP-1:0] ep_ctr_out,
    input logic [7:0]        irq_mask,
    input logic              wr_hit,
    input logic [15:0]       bus_wdata,
    input logic [6:0]        flags_q,
    input logic [15:0]       istr_val,
    input logic              irq,
    input logic              periph_rst
);
    logic [6:0] set_cover;
    assign set_cover = hw_evt | {4'b0, force_rst, 2'b0};

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        istr_val[7:5] == 3'b000);

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((flags_q & ~$past(bus_wdata[14:8]) & ~$past(set_cover)) == 7'b0));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((flags_q & $past(hw_evt)) == $past(hw_evt)));

    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(istr_val[15:8] & irq_mask)));

    a_r7_ctr_summary: assert property (@(posedge clk) disable iff (!rst_n)
        istr_val[15] == (|{ep_ctr_in, ep_ctr_out}));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        force_rst |=> periph_rst);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !force_rst |=> !periph_rst);
endmodule

bind usb_istr usb_istr_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_rst  (force_rst),
    .hw_evt     (hw_evt),
    .ep_ctr_in  (ep_ctr_in),
    .ep_ctr_out (ep_ctr_out),
    .irq_mask   (irq_mask),
    .wr_hit     (wr_hit),
    .bus_wdata  (bus_wdata),
    .flags_q    (flags_q),
    .istr_val   (istr_val),
    .irq        (irq),
    .periph_rst (periph_rst)
);

// File: tb/usb_istr_test.sv
module usb_istr_test;
    localparam int NUM_EP = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              force_rst = 1'b0;
    logic [6:0]        hw_evt = '0;
    logic [NUM_EP-1:0] ep_ctr_in = '0;
    logic [NUM_EP-1:0] ep_ctr_out = '0;
    logic [7:0]        irq_mask = '0;
    logic [7:0]        bus_addr = 8'h44;
    logic              bus_wr = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              irq;
    logic              periph_rst;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [6:0] flags_m = '0;
    logic       held_m = 1'b0;

    always #10 clk = ~clk;

    usb_istr #(.NUM_EP(NUM_EP)) uut (
        .clk(clk), .rst_n(rst_n), .force_rst(force_rst), .hw_evt(hw_evt),
        .ep_ctr_in(ep_ctr_in), .ep_ctr_out(ep_ctr_out), .irq_mask(irq_mask),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .periph_rst(periph_rst)
    );

    function automatic logic [15:0] exp_val(input logic [6:0] f,
                                            input logic [NUM_EP-1:0] pi,
                                            input logic [NUM_EP-1:0] po);
        logic [15:0] v = '0;
        v[14:8] = f;
        v[15]   = |(pi | po);
        for (int i = 0; i < NUM_EP; i++) begin
            if (pi[i] || po[i]) begin
                v[3:0] = 4'(i);
                v[4]   = po[i];
                break;
            end
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input string tag);
        logic [15:0] v;
        @(posedge clk);
        if (bus_wr && bus_addr == 8'h44) flags_m = flags_m & bus_wdata[14:8];
        flags_m = flags_m | hw_evt;
        if (!held_m && force_rst) begin
            flags_m[2] = 1'b1;
            held_m = 1'b1;
        end else if (held_m && !force_rst) begin
            held_m = 1'b0;
        end
        @(negedge clk);
        v = exp_val(flags_m, ep_ctr_in, ep_ctr_out);
        chk({tag, " rdata"}, bus_rdata, (bus_addr == 8'h44) ? v : 16'h0);
        chk("R6 irq", {15'b0, irq}, {15'b0, |(v[15:8] & irq_mask)});
        chk("R9 periph_rst", {15'b0, periph_rst}, {15'b0, held_m});
    endtask

    task automatic idle();
        hw_evt = '0; bus_wr = 1'b0; bus_addr = 8'h44;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset value", bus_rdata, 16'h0000);
        chk("R1 reset irq", {15'b0, irq}, 16'h0);

        // R3: single start-of-frame pulse sets bit 9 and stays
        irq_mask = 8'h00; hw_evt = 7'b0000010; cyc("R3 set SOF");
        idle(); cyc("R3 sticky");
        // R10: all-ones write keeps everything, read-only bits unaffected
        bus_wr = 1'b1; bus_wdata = 16'hFFFF; cyc("R10 ones write");
        idle(); cyc("R10 after write");
        // R1: other address reads zero and writes there do nothing
        bus_addr = 8'h40; bus_wr = 1'b1; bus_wdata = 16'h0000; cyc("R1 other addr");
        idle(); cyc("R10 foreign write ignored");
        // R5: clear and set of SOF together, set wins
        bus_wr = 1'b1; bus_wdata = 16'h0000; hw_evt = 7'b0000010; cyc("R5 set wins");
        // R4: clear SOF only, keep others
        hw_evt = 7'b1000001; bus_wr = 1'b0; cyc("R2 overrun and esof");
        bus_wr = 1'b1; bus_wdata = 16'hFDFF; hw_evt = '0; cyc("R4 partial clear");
        // R6: enable only the expected-SOF bit, then clear it
        idle(); irq_mask = 8'h01; cyc("R6 irq on");
        bus_wr = 1'b1; bus_wdata = 16'hFEFF; cyc("R6 irq off after clear");
        idle(); irq_mask = 8'h40; cyc("R6 remaining enabled flag");
        // R7/R8: endpoint pending patterns
        ep_ctr_in = 8'b0010_1000; ep_ctr_out = 8'b0000_1000; irq_mask = 8'h80; cyc("R8 lowest ep out");
        ep_ctr_in = 8'b1000_0000; ep_ctr_out = 8'b0000_0000; cyc("R7 ep7 in");
        bus_wr = 1'b1; bus_wdata = 16'h7FE0; cyc("R7 write no effect");
        idle(); ep_ctr_in = '0; cyc("R8 none pending");
        // R9: force reset held then released
        force_rst = 1'b1; bus_wr = 1'b1; bus_wdata = 16'h0000; cyc("R9 enter");
        idle(); cyc("R9 held");
        bus_wr = 1'b1; bus_wdata = 16'h0000; cyc("R9 no re-set while held");
        idle(); force_rst = 1'b0; cyc("R9 release");

        for (int i = 0; i < 3000; i++) begin
            hw_evt     = 7'($urandom & $urandom & $urandom);
            bus_wr     = ($urandom % 3) == 0;
            bus_addr   = (($urandom % 5) == 0) ? 8'($urandom) : 8'h44;
            bus_wdata  = 16'($urandom);
            irq_mask   = 8'($urandom);
            ep_ctr_in  = NUM_EP'($urandom & $urandom & $urandom);
            ep_ctr_out = NUM_EP'($urandom & $urandom & $urandom);
            if (($urandom % 25) == 0) force_rst = ~force_rst;
            cyc("R3 R4 R5 R8 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule